// File: doc/BRIEF.md
# Bank Protection Status Scanner

This block walks over the write-protect bits of a flash array, one bank per clock cycle, and folds them into a small summary word. Each bank is either part of a read-only region or part of the rest of the array. The read-only region is a window of consecutive banks whose first bank and length are parameters. For each region the summary reports whether any bank is protected. It also reports whether a region mixes protected and unprotected banks in a way the scan can see. A further bit reports the hardware write-protect line, and that bit is always set.

The protect bits arrive as a packed vector of option bytes. A one-cycle start pulse takes a snapshot of that vector, clears the summary and starts the walk at bank 0. A one-cycle done pulse marks the end of the walk, and from then on the summary is final. The mixed-protection bit depends on the order of the walk. It is raised only when an unprotected bank comes after a protected bank of the same region. An unprotected bank that comes before the first protected bank of its region does not raise it.

Top module: `bank_prot_scan`

## Requirements
- R1: The protect bit of bank n is bit n%8 of option byte n/8, and option byte k occupies bits 8k+7 down to 8k of `prot_bytes_i`, so bank n reads bit n. Padding bits above bank NUM_BANKS-1 are never used.
- R2: A bank whose index lies in [RO_FIRST, RO_FIRST+RO_BANKS) belongs to the read-only region. Every other bank belongs to the rest-of-array region.
- R3: When a scan reaches a protected bank, that bank sets its region's flag. `flags_o[1]` is the read-only region flag and `flags_o[2]` is the rest-of-array flag.
- R4: `flags_o[3]` (mixed) is set when the scan reaches an unprotected bank whose region flag was already set by a lower-indexed bank. It is never set by an unprotected bank that comes before every protected bank of its region.
- R5: `flags_o[0]` (write-protect line asserted) reads 1 at all times, reset included.
- R6: After reset, `flags_o` is 4'b0001 and `done_o` is 0.
- R7: A start pulse seen while idle clears `flags_o[3:1]` at that clock edge. Banks are then processed in increasing order from bank 0, one per cycle.
- R8: `done_o` is high for exactly one cycle, following the NUM_BANKS-th edge after the edge that accepted the start. At that point `flags_o` holds the final summary.
- R9: A start pulse during a scan is ignored. The scan neither restarts nor changes its timing.
- R10: The protect vector is captured at the edge that accepts the start. Changes to it during the scan do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| prot_bytes_i | input | 8*ceil(NUM_BANKS/8) | Packed option bytes, byte 0 in the low bits |
| flags_o | output | 4 | {mixed, rest protected, read-only protected, write-protect line} |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
Call the edge that accepts the start edge 0. The cleared summary is due right after edge 0. Bank n is folded in at edge n+1, so the done pulse and the final summary are due right after edge NUM_BANKS, and done must be low again one edge later. The bench drives and samples only on falling edges and counts them from the start pulse. It checks the cleared summary after the first falling edge. It checks that done stays low up to the NUM_BANKS-th falling edge, that done and the expected summary appear at the next one, and that done is low again at the one after. For a second start issued mid-scan, the bench expects exactly the same falling-edge count and the summary computed from the vector captured first.

// File: rtl/bank_prot_pkg.sv
package bank_prot_pkg;

  localparam int SUM_W = 4;

  // Summary word: bit3 mixed, bit2 rest-of-array, bit1 read-only, bit0 wp line
  typedef struct packed {
    logic mixed;
    logic rest_prot;
    logic ro_prot;
    logic wp_line;
  } prot_sum_t;

  localparam prot_sum_t SUM_CLEAR = '{mixed: 1'b0, rest_prot: 1'b0,
                                      ro_prot: 1'b0, wp_line: 1'b1};

endpackage

// File: rtl/bank_prot_pick.sv
module bank_prot_pick #(
  parameter int NUM_BANKS = 20,
  parameter int IDX_W     = 5,
  parameter int NBYTES    = 3
) (
  input  logic [NBYTES*8-1:0] snap_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                bit_o
);

  logic [7:0]  opt_byte [NBYTES];
  logic [31:0] idx_wide;
  logic [28:0] byte_no;
  logic [2:0]  bit_no;
  logic [7:0]  sel_byte;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    assign opt_byte[b] = snap_i[b*8 +: 8];
  end

  assign idx_wide = 32'(idx_i);
  assign byte_no  = idx_wide[31:3];
  assign bit_no   = idx_wide[2:0];

  always_comb begin
    sel_byte = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (byte_no == 29'(b)) sel_byte = opt_byte[b];
    end
  end

  assign bit_o = sel_byte[bit_no];

endmodule

// File: rtl/bank_prot_region.sv
module bank_prot_region #(
  parameter int IDX_W    = 5,
  parameter int RO_FIRST = 4,
  parameter int RO_BANKS = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             in_ro_o
);

  localparam logic [31:0] LO = 32'(RO_FIRST);
  localparam logic [31:0] HI = 32'(RO_FIRST + RO_BANKS);

  logic [31:0] idx_wide;

  assign idx_wide = 32'(idx_i);
  assign in_ro_o  = (idx_wide >= LO) && (idx_wide < HI);

endmodule

// File: rtl/bank_prot_acc.sv
module bank_prot_acc
  import bank_prot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      step_i,
  input  logic      bank_prot_i,
  input  logic      in_ro_i,
  output prot_sum_t sum_o
);

  prot_sum_t sum_q, sum_d;
  logic      region_set;

  assign region_set = in_ro_i ? sum_q.ro_prot : sum_q.rest_prot;

  always_comb begin
    sum_d = sum_q;
    if (clr_i) begin
      sum_d = SUM_CLEAR;
    end else if (step_i) begin
      if (bank_prot_i) begin
        if (in_ro_i) sum_d.ro_prot   = 1'b1;
        else         sum_d.rest_prot = 1'b1;
      end else if (region_set) begin
        sum_d.mixed = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= SUM_CLEAR;
    else if (clr_i || step_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/bank_prot_ctrl.sv
module bank_prot_ctrl #(
  parameter int NUM_BANKS = 20,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign load_o = accept;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

endmodule

// File: rtl/bank_prot_scan.sv
module bank_prot_scan
  import bank_prot_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int RO_FIRST  = 4,
  parameter int RO_BANKS  = 6,
  localparam int NBYTES   = (NUM_BANKS + 7) / 8,
  localparam int VEC_W    = NBYTES * 8,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] prot_bytes_i,
  output logic [SUM_W-1:0] flags_o,
  output logic             done_o
);

  logic             scan_load;
  logic             scan_busy;
  logic [IDX_W-1:0] scan_idx;
  logic [VEC_W-1:0] snap_q;
  logic             cur_prot;
  logic             cur_in_ro;
  prot_sum_t        sum;

  bank_prot_ctrl #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .load_o (scan_load),
    .busy_o (scan_busy),
    .idx_o  (scan_idx),
    .done_o (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else if (scan_load) snap_q <= prot_bytes_i;
  end

  bank_prot_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .NBYTES(NBYTES)) u_pick (
    .snap_i(snap_q),
    .idx_i (scan_idx),
    .bit_o (cur_prot)
  );

  bank_prot_region #(.IDX_W(IDX_W), .RO_FIRST(RO_FIRST), .RO_BANKS(RO_BANKS)) u_region (
    .idx_i  (scan_idx),
    .in_ro_o(cur_in_ro)
  );

  bank_prot_acc u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (scan_load),
    .step_i     (scan_busy),
    .bank_prot_i(cur_prot),
    .in_ro_i    (cur_in_ro),
    .sum_o      (sum)
  );

  assign flags_o = sum;

endmodule

// File: rtl/bank_prot_scan_chk.sv
module bank_prot_scan_chk #(
  parameter int NUM_BANKS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy,
  input logic [3:0] flags_o,
  input logic       done_o
);

  logic [31:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (start_i && !busy) since_q <= 32'd1;
    else if (busy) since_q <= since_q + 32'd1;
  end

  p_wp_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[0] == 1'b1);

  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (flags_o[3:1] == 3'b000));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (since_q == 32'(NUM_BANKS + 1)));

  p_mixed_after_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[3]) |-> $past(flags_o[1] || flags_o[2]));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!$fell(flags_o[1]) && !$fell(flags_o[2]) && !$fell(flags_o[3])));

endmodule

bind bank_prot_scan bank_prot_scan_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy   (scan_busy),
  .flags_o(flags_o),
  .done_o (done_o)
);

// File: tb/bank_prot_scan_test.sv
module bank_prot_scan_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 20;
  localparam int ROF  = 4;
  localparam int ROC  = 6;
  localparam int VW   = ((NB + 7) / 8) * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [VW-1:0] prot_bytes_i;
  logic [3:0]    flags_o;
  logic          done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_prot_scan #(.NUM_BANKS(NB), .RO_FIRST(ROF), .RO_BANKS(ROC)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .prot_bytes_i(prot_bytes_i),
    .flags_o     (flags_o),
    .done_o      (done_o)
  );

  function automatic logic [3:0] model(input logic [VW-1:0] v);
    logic ro, rest, mix, p, inro;
    ro = 0; rest = 0; mix = 0;
    for (int n = 0; n < NB; n++) begin
      p    = v[(n/8)*8 + (n%8)];
      inro = (n >= ROF) && (n < ROF + ROC);
      if (p) begin
        if (inro) ro = 1; else rest = 1;
      end else if (inro ? ro : rest) begin
        mix = 1;
      end
    end
    return {mix, rest, ro, 1'b1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // midhit: falling-edge index at which a second start and a new vector are applied (0 = none)
  task automatic run_scan(input logic [VW-1:0] v, input string req, input int midhit);
    logic [3:0] exp;
    logic       early;
    exp = model(v);
    early = 1'b0;
    @(negedge clk);
    prot_bytes_i = v;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 cleared", 32'(flags_o), 32'h1);
    for (int k = 2; k <= NB; k++) begin
      @(negedge clk);
      if (done_o) early = 1'b1;
      if (k == midhit) begin
        start_i = 1'b1;
        prot_bytes_i = ~v;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    check("R8 no early done", 32'(early), 32'h0);
    @(negedge clk);
    check("R8 done pulse", 32'(done_o), 32'h1);
    check(req, 32'(flags_o), 32'(exp));
    @(negedge clk);
    check("R8 done single", 32'(done_o), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    start_i = 1'b0;
    prot_bytes_i = '0;
    #(CLK_PERIOD * 2 + 1);
    check("R6 reset flags", 32'(flags_o), 32'h1);
    check("R6 reset done", 32'(done_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 wp bit idle", 32'(flags_o[0]), 32'h1);

    run_scan('0, "R3 none protected", 0);
    run_scan('1, "R3 all protected", 0);
    // R2: only the read-only window protected, no mixing
    v = '0;
    for (int n = ROF; n < ROF + ROC; n++) v[n] = 1'b1;
    run_scan(v, "R2 ro window only", 0);
    // R4: unprotected before protected in a region does not mix
    v = '0;
    v[ROF + ROC - 1] = 1'b1;
    v[NB - 1] = 1'b1;
    run_scan(v, "R4 late protect no mix", 0);
    // R4: protected then unprotected mixes (rest region, bank 0 then bank 1)
    v = '0;
    v[0] = 1'b1;
    run_scan(v, "R4 early protect mixes", 0);
    // R1: single protected bank, every position, padding bits set
    for (int n = 0; n < NB; n++) begin
      v = '0;
      for (int p = NB; p < VW; p++) v[p] = 1'b1;
      v[n] = 1'b1;
      run_scan(v, "R1 single bank", 0);
    end
    // R9 / R10: second start and vector change mid-scan
    v = '0;
    for (int n = ROF; n < ROF + ROC; n++) v[n] = 1'b1;
    run_scan(v, "R9 R10 mid-scan start ignored", 5);
    run_scan(24'h0F0F0F, "R10 mid-scan vector change", 9);
    // random patterns
    for (int t = 0; t < 40; t++) begin
      v = VW'($urandom());
      run_scan(v, "R3 R4 random", (t % 4 == 0) ? 7 : 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule